// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Memory Decoder

This block sits between a microcontroller bus and a bank of external memory devices of 32 KB each. On that bus the low address byte and the data byte share one set of eight pins. During the address phase of an access the processor raises an address latch enable. The block captures the low byte at that point and keeps it on the memory address lines for the rest of the access. The dedicated high address lines pass straight through to the devices.

The top two address bits choose one of three device windows. Each window has its own active-low chip select. The fourth window is unpopulated. The processor read strobe drives the memories' output enable. The write strobe drives their write enable, except in the read-only window and the unpopulated window, where the write is blocked.

A direction signal tells the external data transceiver when the processor drives data toward the memories. A registered fault flag reports any strobe that lands in the unpopulated window and any write aimed at the read-only device.

Top module: `mux_bus_decoder`

## Requirements
- R1: On a rising clock edge where `ale_i` is high, the value on `ad_i` is captured. It appears on `mem_addr_o[7:0]` from the following cycle.
- R2: While `ale_i` is low, `mem_addr_o[7:0]` holds its value whatever `ad_i` carries, including the data byte of the access.
- R3: `mem_addr_o[14:8]` equals `hi_addr_i[6:0]` in the same cycle, with no register between them.
- R4: The select field `hi_addr_i[8:7]` drives the chip selects combinationally. Value 0 drives `cs_n_o[0]` low, value 1 drives `cs_n_o[1]` low and value 2 drives `cs_n_o[2]` low. Value 3 leaves all three chip selects high. No more than one chip select is ever low.
- R5: `oe_n_o` equals `rd_n_i` in the same cycle in every window.
- R6: `we_n_o` equals `wr_n_i` when the select field is 0 or 1. It stays high when the select field is 2 (the read-only device) or 3.
- R7: `dir_o` is high exactly when `we_n_o` is low.
- R8: `fault_o` is high in the cycle after a rising edge where either of two conditions holds. The first is a select field of 3 with `rd_n_i` or `wr_n_i` low. The second is a select field of 2 with `wr_n_i` low. In all other cycles `fault_o` is low.
- R9: While `rst_n` is low, the latched byte is cleared to 0 and `fault_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_i | input | 8 | Shared pins: low address byte, then data byte |
| hi_addr_i | input | 9 | Dedicated address bits 16 to 8 |
| ale_i | input | 1 | Address latch enable, active high |
| rd_n_i | input | 1 | Processor read strobe, active low |
| wr_n_i | input | 1 | Processor write strobe, active low |
| mem_addr_o | output | 15 | Address to the memory devices |
| cs_n_o | output | 3 | Active-low chip select, one per window |
| oe_n_o | output | 1 | Output enable to the memories, active low |
| we_n_o | output | 1 | Write enable to the memories, active low |
| dir_o | output | 1 | High while the processor drives data toward the memories |
| fault_o | output | 1 | Strobe in the unpopulated window or write to the read-only window |

## Verification
Two results lag their stimulus by exactly one clock: the latched low byte and the fault flag. Both are registered, so they change at the rising edge that samples the stimulus. The high address bits, the chip selects, the output enable, the write enable and the direction signal are all combinational and follow their inputs within the same cycle. The bench applies new inputs at the falling edge. Its reference model advances its latch and fault state at each rising edge from the inputs held at that edge. Every output is then compared at the next falling edge, so both the same-cycle results and the one-cycle results are checked in the cycle they are due.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

   // Number of address bits consumed by the window select field
   function automatic int sel_width(input int lo_w, input int hi_w, input int dev_aw);
      return lo_w + hi_w - dev_aw;
   endfunction

endpackage

// File: rtl/mbd_addr_latch.sv
module mbd_addr_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ale,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (ale) begin
         hold_q <= d;
      end
   end

   assign q = hold_q;

endmodule

// File: rtl/mbd_region_decode.sv
module mbd_region_decode #(
   parameter int               SEL_W    = 2,
   parameter int               N_SEL    = 3,
   parameter logic [N_SEL-1:0] ROM_MASK = '0
) (
   input  logic [SEL_W-1:0] sel,
   output logic [N_SEL-1:0] cs_n,
   output logic             valid,
   output logic             rom
);

   logic [N_SEL-1:0] hit;

   for (genvar g = 0; g < N_SEL; g++) begin : g_sel
      localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
      assign hit[g]  = (sel == IDX);
      assign cs_n[g] = ~hit[g];
   end

   assign valid = |hit;
   assign rom   = |(hit & ROM_MASK);

endmodule

// File: rtl/mbd_strobe_map.sv
module mbd_strobe_map (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic valid,
   input  logic rom,
   output logic oe_n,
   output logic we_n,
   output logic dir,
   output logic fault
);

   logic write_ok;
   logic bad_access;
   logic fault_q;

   assign write_ok   = valid && !rom;
   assign oe_n       = rd_n;
   assign we_n       = write_ok ? wr_n : 1'b1;
   assign dir        = !we_n;
   assign bad_access = (!valid && (!rd_n || !wr_n)) || (rom && !wr_n);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
      end else begin
         fault_q <= bad_access;
      end
   end

   assign fault = fault_q;

endmodule

// File: rtl/mux_bus_decoder.sv
module mux_bus_decoder #(
   parameter int               LO_W     = 8,
   parameter int               HI_W     = 9,
   parameter int               DEV_AW   = 15,
   parameter int               N_SEL    = 3,
   parameter logic [N_SEL-1:0] ROM_MASK = 3'b100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LO_W-1:0]   ad_i,
   input  logic [HI_W-1:0]   hi_addr_i,
   input  logic              ale_i,
   input  logic              rd_n_i,
   input  logic              wr_n_i,
   output logic [DEV_AW-1:0] mem_addr_o,
   output logic [N_SEL-1:0]  cs_n_o,
   output logic              oe_n_o,
   output logic              we_n_o,
   output logic              dir_o,
   output logic              fault_o
);

   localparam int SEL_W  = mbd_pkg::sel_width(LO_W, HI_W, DEV_AW);
   localparam int PASS_W = HI_W - SEL_W;

   if (SEL_W < 1) begin : g_bad_sel
      $error("window select field must be at least one bit wide");
   end
   if (N_SEL > (1 << SEL_W)) begin : g_bad_nsel
      $error("more chip selects than the select field can encode");
   end
   if (DEV_AW <= LO_W) begin : g_bad_aw
      $error("device address must be wider than the shared byte");
   end

   logic [LO_W-1:0]  lo_byte;
   logic [SEL_W-1:0] sel_field;
   logic             win_valid;
   logic             win_rom;

   assign sel_field = hi_addr_i[HI_W-1 -: SEL_W];

   mbd_addr_latch #(.W(LO_W)) u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .ale  (ale_i),
      .d    (ad_i),
      .q    (lo_byte)
   );

   mbd_region_decode #(
      .SEL_W   (SEL_W),
      .N_SEL   (N_SEL),
      .ROM_MASK(ROM_MASK)
   ) u_dec (
      .sel  (sel_field),
      .cs_n (cs_n_o),
      .valid(win_valid),
      .rom  (win_rom)
   );

   mbd_strobe_map u_strb (
      .clk  (clk),
      .rst_n(rst_n),
      .rd_n (rd_n_i),
      .wr_n (wr_n_i),
      .valid(win_valid),
      .rom  (win_rom),
      .oe_n (oe_n_o),
      .we_n (we_n_o),
      .dir  (dir_o),
      .fault(fault_o)
   );

   assign mem_addr_o = {hi_addr_i[PASS_W-1:0], lo_byte};

endmodule

// File: rtl/mbd_checker.sv
module mbd_checker #(
   parameter int LO_W   = 8,
   parameter int HI_W   = 9,
   parameter int DEV_AW = 15,
   parameter int N_SEL  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LO_W-1:0]   ad_i,
   input logic [HI_W-1:0]   hi_addr_i,
   input logic              ale_i,
   input logic              rd_n_i,
   input logic              wr_n_i,
   input logic [DEV_AW-1:0] mem_addr_o,
   input logic [N_SEL-1:0]  cs_n_o,
   input logic              oe_n_o,
   input logic              we_n_o,
   input logic              dir_o,
   input logic              fault_o
);

   localparam int SEL_W = LO_W + HI_W - DEV_AW;

   logic [SEL_W-1:0] win;
   assign win = hi_addr_i[HI_W-1 -: SEL_W];

   p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ale_i |=> (mem_addr_o[LO_W-1:0] == $past(ad_i)));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ale_i |=> $stable(mem_addr_o[LO_W-1:0]));

   p_single_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n_o));

   p_empty_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(win) >= N_SEL) |-> (&cs_n_o));

   p_oe_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n_o == rd_n_i);

   p_rom_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win == SEL_W'(2)) |-> we_n_o);

   p_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dir_o |-> (!we_n_o && !wr_n_i));

   p_rom_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((win == SEL_W'(2)) && !wr_n_i) |=> fault_o);

endmodule

bind mux_bus_decoder mbd_checker #(
   .LO_W  (LO_W),
   .HI_W  (HI_W),
   .DEV_AW(DEV_AW),
   .N_SEL (N_SEL)
) u_chk (.*);

// File: tb/sim_mux_bus_decoder.sv
module sim_mux_bus_decoder;

   localparam int PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ad_i = '0;
   logic [8:0]  hi_addr_i = '0;
   logic        ale_i = 1'b0;
   logic        rd_n_i = 1'b1;
   logic        wr_n_i = 1'b1;
   logic [14:0] mem_addr_o;
   logic [2:0]  cs_n_o;
   logic        oe_n_o;
   logic        we_n_o;
   logic        dir_o;
   logic        fault_o;

   int n_cmp = 0;
   int n_bad = 0;
   int m_lo = 0;
   int m_fault = 0;

   always #(PER/2) clk = ~clk;

   mux_bus_decoder u0 (.*);

   // behavioural reference: state advances on the rising edge
   always @(posedge clk) begin
      int w;
      w = int'(hi_addr_i[8:7]);
      if (!rst_n) begin
         m_lo = 0;
         m_fault = 0;
      end else begin
         if (ale_i) m_lo = int'(ad_i);
         m_fault = ((w == 3 && (!rd_n_i || !wr_n_i)) || (w == 2 && !wr_n_i)) ? 1 : 0;
      end
   end

   task automatic cmp(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int w;
      int e_cs;
      int e_we;
      w = int'(hi_addr_i[8:7]);
      e_cs = (w < 3) ? (7 & ~(1 << w)) : 7;
      e_we = (w < 2) ? int'(wr_n_i) : 1;
      cmp("R1/R2 low address byte", int'(mem_addr_o[7:0]), m_lo);
      cmp("R3 high address bits", int'(mem_addr_o[14:8]), int'(hi_addr_i[6:0]));
      cmp("R4 chip selects", int'(cs_n_o), e_cs);
      cmp("R5 output enable", int'(oe_n_o), int'(rd_n_i));
      cmp("R6 write enable", int'(we_n_o), e_we);
      cmp("R7 direction", int'(dir_o), (e_we == 0) ? 1 : 0);
      cmp("R8 fault flag", int'(fault_o), m_fault);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   // address phase, data phase with strobe, idle phase
   task automatic bus_access(input int addr, input int data, input bit is_wr);
      hi_addr_i = 9'(addr >> 8);
      ad_i = 8'(addr);
      ale_i = 1'b1;
      tick();
      ale_i = 1'b0;
      ad_i = 8'(data);
      if (is_wr) wr_n_i = 1'b0; else rd_n_i = 1'b0;
      tick();
      tick();
      rd_n_i = 1'b1;
      wr_n_i = 1'b1;
      ad_i = 8'(~data);
      tick();
   endtask

   initial begin
      int seed;
      @(negedge clk);
      ad_i = 8'hA5;
      ale_i = 1'b1;
      tick();
      // R9: reset clears the latch and the fault flag
      cmp("R9 reset low byte", int'(mem_addr_o[7:0]), 0);
      cmp("R9 reset fault", int'(fault_o), 0);
      hi_addr_i = 9'h180;
      rd_n_i = 1'b0;
      tick();
      cmp("R9 reset fault in empty window", int'(fault_o), 0);
      rd_n_i = 1'b1;
      ale_i = 1'b0;
      rst_n = 1'b1;
      tick();

      bus_access(17'h00123, 8'h5A, 1'b0);   // R1 R5 read, window 0
      bus_access(17'h07FFF, 8'h3C, 1'b1);   // R6 write, window 0 top
      bus_access(17'h08000, 8'hC3, 1'b1);   // R4 window 1 bottom
      bus_access(17'h0FFFF, 8'h11, 1'b0);   // window 1 top
      bus_access(17'h10000, 8'h22, 1'b0);   // R4 read-only window read
      bus_access(17'h17FFF, 8'h33, 1'b1);   // R6 R8 blocked write
      bus_access(17'h18000, 8'h44, 1'b0);   // R8 empty window read
      bus_access(17'h1FFFF, 8'h55, 1'b1);   // R8 empty window write

      // R2: data bus churn with ALE low leaves the byte alone
      for (int i = 0; i < 8; i++) begin
         ad_i = 8'(i * 37 + 1);
         tick();
      end

      seed = 32'h1D2C3B4A;
      for (int i = 0; i < 300; i++) begin
         seed = seed * 1103515245 + 12345;
         bus_access((seed >>> 8) & 32'h1FFFF, (seed >>> 3) & 255, seed[30]);
      end
      for (int i = 0; i < 200; i++) begin
         seed = seed * 1103515245 + 12345;
         ad_i = 8'(seed >>> 5);
         hi_addr_i = 9'(seed >>> 13);
         ale_i = seed[24];
         rd_n_i = seed[25];
         wr_n_i = seed[26];
         tick();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(PER * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule